// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches 16-bit words from a three-wire serial configuration EEPROM on behalf of a host. The host gives a starting word address, a number of words and a byte-order flag, then pulses a request. The block drives chip select, serial clock and serial data toward the memory and samples the memory's data output. It hands back each word with a one-cycle strobe, and it flags completion once the last word's access has fully closed.

Every word is fetched by its own complete access. The access begins with an idle/reset clocking run that puts the memory into a known state. A read command carrying the word address follows, then sixteen data clocks, and a second idle run closes the access. Each half of a serial clock period lasts `HALF_CYC` system clocks. Set `HALF_CYC` so that a full bit period is at least 300 ns at the system clock rate in use. Only the low six bits of the word address are kept, so a multi-word read wraps from address 63 back to 0.

Top module: `seeprom_word_reader`

## Requirements
- R1: While reset is held, and after it is released with no request, `busy`, `word_vld`, `done`, `ee_cs`, `ee_sk` and `ee_di` are all low.
- R2: A request with a nonzero `word_count` is taken only while `busy` is low, and `busy` is high from the next cycle until the closing idle run of the last word ends. A request while `busy` is high, or a request with a zero count, has no effect.
- R3: Each word access opens and closes with an idle run. Chip select goes high with the clock low, and the clock is raised once. The clock then makes 25 low-to-high toggles, drops low, and chip select then drops. The opening run forms a chip-select-high window on its own with 26 rising clock edges. The command, data and closing run share a second window with 12 + 16 + 26 = 54 rising edges.
- R4: The read command is 11 bits sent MSB first. Bits 10:8 are 3'b110, bits 7:6 are zero and bits 5:0 are the word address, so the value is 0x600 OR the address. `ee_di` is set while the clock is low and stays stable across the following rising edge.
- R5: After the command, 16 data bits are clocked in MSB first, and each bit is sampled at the end of the clock-high half.
- R6: A read of N words fetches N consecutive addresses from the start address. Only the low 6 bits of `start_addr` are used, bits 7:6 are ignored, and the address wraps modulo 64.
- R7: With `swap` set at the request, each returned word has its two bytes exchanged: memory bits 15:8 appear on `word_data[7:0]`.
- R8: `word_vld` pulses for exactly one cycle per word, `word_count` times per request. `done` is a one-cycle pulse in the same cycle that `busy` first reads low.
- R9: Every high phase of `ee_sk` lasts exactly `HALF_CYC` system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-cycle read request |
| start_addr | input | 8 | First word address (only bits 5:0 used) |
| word_count | input | CNT_W | Number of words to read |
| swap | input | 1 | Exchange bytes of each returned word |
| busy | output | 1 | Transfer in progress |
| word_vld | output | 1 | One-cycle strobe for `word_data` |
| word_data | output | 16 | Returned word |
| done | output | 1 | One-cycle end-of-transfer pulse |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of a running transfer. It must leave the remaining words, their addresses and the byte order untouched. The bench raises such a request partway into a two-word read, with different parameters, and then checks every returned word and command against the first request only. Address wrap and the discarding of address bits 7:6 show only in the command bits on the serial wire. A small memory model in the bench captures each command, and start addresses near 63 with high bits set make the wrap visible.

// File: rtl/seeprom_word_reader.sv
module seeprom_word_reader #(
  parameter int HALF_CYC = 16,
  parameter int ADDR_W   = 6,
  parameter int CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [7:0]       start_addr,
  input  logic [CNT_W-1:0] word_count,
  input  logic             swap,
  output logic             busy,
  output logic             word_vld,
  output logic [15:0]      word_data,
  output logic             done,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_di,
  input  logic             ee_do
);

  localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [TW-1:0] T_END = TW'(HALF_CYC - 1);
  localparam logic [5:0] IDL_END = 6'd53;
  localparam logic [5:0] IDL_LAST_HI = 6'd51;
  localparam logic [5:0] CMD_END = 6'd23;
  localparam logic [5:0] DAT_END = 6'd31;
  localparam logic [2:0] RD_OP = 3'b110;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_CMD, S_DATA, S_POST} st_t;

  st_t              st;
  logic [TW-1:0]    tick;
  logic [5:0]       step, step_lim;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0] left;
  logic             swap_q;
  logic [15:0]      shreg, nxt;
  logic [10:0]      cmd;
  logic [3:0]       cidx;
  logic             adv, last;

  assign cmd  = {RD_OP, 8'(addr)};
  assign adv  = (tick == T_END);
  assign last = adv && (step == step_lim);
  assign busy = (st != S_IDLE);
  assign nxt  = {shreg[14:0], ee_do};
  assign cidx = 4'd10 - 4'((step - 6'd2) >> 1);

  always_comb begin
    case (st)
      S_CMD:   step_lim = CMD_END;
      S_DATA:  step_lim = DAT_END;
      default: step_lim = IDL_END;
    endcase
  end

  always_comb begin
    ee_cs = 1'b0;
    ee_sk = 1'b0;
    ee_di = 1'b0;
    case (st)
      S_PRE, S_POST: begin
        ee_cs = (step != IDL_END);
        ee_sk = step[0] && (step <= IDL_LAST_HI);
      end
      S_CMD: begin
        ee_cs = 1'b1;
        ee_sk = step[0];
        ee_di = (step >= 6'd2) ? cmd[cidx] : 1'b0;
      end
      S_DATA: begin
        ee_cs = 1'b1;
        ee_sk = step[0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tick      <= '0;
      step      <= '0;
      addr      <= '0;
      left      <= '0;
      swap_q    <= 1'b0;
      shreg     <= '0;
      word_data <= '0;
      word_vld  <= 1'b0;
      done      <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      done     <= 1'b0;
      if (st == S_IDLE) begin
        tick <= '0;
        step <= '0;
        if (req && (word_count != '0)) begin
          st     <= S_PRE;
          addr   <= start_addr[ADDR_W-1:0];
          left   <= word_count;
          swap_q <= swap;
        end
      end else begin
        tick <= adv ? '0 : tick + 1'b1;
        if (adv) step <= last ? 6'd0 : step + 6'd1;
        if (st == S_DATA && adv && step[0]) shreg <= nxt;
        if (last) begin
          case (st)
            S_PRE:  st <= S_CMD;
            S_CMD:  st <= S_DATA;
            S_DATA: begin
              st        <= S_POST;
              word_vld  <= 1'b1;
              word_data <= swap_q ? {nxt[7:0], nxt[15:8]} : nxt;
            end
            default: begin
              if (left == CNT_W'(1)) begin
                st   <= S_IDLE;
                done <= 1'b1;
              end else begin
                st   <= S_PRE;
                left <= left - 1'b1;
                addr <= addr + 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk && !word_vld)); // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req && word_count != '0) |=> busy); // R2
  AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs); // R3
  AST_DI_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD && $rose(ee_sk)) |-> $stable(ee_di)); // R4
  AST_VLD_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> (st == S_POST && $past(st == S_DATA))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8

endmodule

// File: tb/sim_seeprom_word_reader.sv
module sim_seeprom_word_reader;
  localparam int CLK_PERIOD = 10;
  localparam int HC = 3;
  localparam int CW = 7;
  localparam int NVEC = 5;
  // packed {start_addr[7:0], word_count[6:0], swap}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'h00, 7'd2, 1'b0},
    {8'h11, 7'd3, 1'b1},
    {8'hFE, 7'd3, 1'b0},
    {8'h7F, 7'd2, 1'b1},
    {8'h2A, 7'd1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, swap = 1'b0, ee_do = 1'b0;
  logic [7:0] start_addr = '0;
  logic [CW-1:0] word_count = '0;
  logic busy, word_vld, done, ee_cs, ee_sk, ee_di;
  logic [15:0] word_data;

  seeprom_word_reader #(.HALF_CYC(HC), .ADDR_W(6), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .start_addr(start_addr),
    .word_count(word_count), .swap(swap), .busy(busy), .word_vld(word_vld),
    .word_data(word_data), .done(done), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mem(input logic [5:0] a);
    return {2'b10, a, 2'b01, ~a};
  endfunction

  // memory model and wire monitor
  int win_q[$];
  logic [10:0] cmd_q[$];
  logic psk = 0, pcs = 0;
  int msta = 0, ncmd = 0, nd = 0, ecount = 0, hcnt = 0, bad_hi = 0, hi_total = 0;
  logic [10:0] mcmd = '0;
  logic [15:0] mword;

  always @(negedge clk) begin
    if (ee_cs && ee_sk && !psk) begin
      ecount++;
      if (msta == 0) begin
        if (ee_di) begin msta = 1; mcmd = 11'd1; ncmd = 1; end
      end else if (msta == 1) begin
        mcmd = {mcmd[9:0], ee_di};
        ncmd++;
        if (ncmd == 11) begin msta = 2; nd = 0; cmd_q.push_back(mcmd); end
      end else if (msta == 2) begin
        mword = mem(mcmd[5:0]);
        ee_do = mword[15-nd];
        nd++;
        if (nd == 16) msta = 3;
      end
    end
    if (!ee_cs && pcs) begin
      win_q.push_back(ecount);
      ecount = 0;
      msta = 0;
    end
    if (ee_sk) hcnt++;
    else if (psk) begin
      hi_total++;
      if (hcnt != HC) bad_hi++;
      hcnt = 0;
    end
    psk = ee_sk;
    pcs = ee_cs;
  end

  task automatic run_vec(input logic [7:0] a, input int cnt, input logic sw, input bit inject);
    int got = 0, cyc = 0;
    bit done_seen = 0;
    logic [5:0] wa;
    logic [15:0] ew;
    win_q.delete();
    cmd_q.delete();
    @(negedge clk);
    req = 1; start_addr = a; word_count = CW'(cnt); swap = sw;
    @(negedge clk);
    req = 0;
    check(busy == 1'b1, "R2 busy after request", int'(busy), 1);
    while (!done_seen && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 40) begin
        req = 1; start_addr = 8'h28; word_count = CW'(5); swap = ~sw;
      end else req = 0;
      if (word_vld) begin
        wa = a[5:0] + 6'(got);
        ew = mem(wa);
        if (sw) ew = {ew[7:0], ew[15:8]};
        check(word_data == ew, sw ? "R7 swapped word" : "R5 word data", int'(word_data), int'(ew));
        got++;
      end
      if (done) begin
        done_seen = 1;
        check(busy == 1'b0, "R8 done with busy low", int'(busy), 0);
      end
    end
    check(done_seen, "R8 done seen", int'(done_seen), 1);
    check(got == cnt, "R8 word strobes", got, cnt);
    check(cmd_q.size() == cnt, "R4 command count", cmd_q.size(), cnt);
    foreach (cmd_q[i]) begin
      wa = a[5:0] + 6'(i);
      check(cmd_q[i] == (11'h600 | 11'(wa)), "R6 R4 command value", int'(cmd_q[i]), int'(11'h600 | 11'(wa)));
    end
    check(win_q.size() == 2 * cnt, "R3 select windows", win_q.size(), 2 * cnt);
    foreach (win_q[i])
      check(win_q[i] == ((i % 2 == 0) ? 26 : 54), "R3 rising edges per window", win_q[i], (i % 2 == 0) ? 26 : 54);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R8 done pulse ends", int'({done, busy}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({busy, word_vld, done, ee_cs, ee_sk, ee_di} == 6'b0, "R1 outputs in reset",
          int'({busy, word_vld, done, ee_cs, ee_sk, ee_di}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check({busy, word_vld, done, ee_cs, ee_sk, ee_di} == 6'b0, "R1 outputs after reset",
          int'({busy, word_vld, done, ee_cs, ee_sk, ee_di}), 0);

    for (int v = 0; v < NVEC; v++)
      run_vec(VEC[v][15:8], int'(VEC[v][7:1]), VEC[v][0], 1'b0);

    // R2: request during a transfer is ignored
    run_vec(8'h05, 2, 1'b0, 1'b1);

    // R2: zero-count request is ignored
    @(negedge clk);
    req = 1; start_addr = 8'h10; word_count = '0;
    @(negedge clk);
    req = 0;
    repeat (5) @(negedge clk);
    check(busy == 1'b0 && ee_cs == 1'b0, "R2 zero count ignored", int'({busy, ee_cs}), 0);

    check(hi_total > 0 && bad_hi == 0, "R9 clock high phase length", bad_hi, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: actual %0h expected %0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule